// File: doc/BRIEF.md
# Indirect Configuration Register Port with Keyed Soft Reset

This block sits between a host's byte-wide parallel bus and the configuration side of a serial bus controller. The host sees two locations, chosen by `win_sel`. One holds a small pointer. The other is a data window that reaches whichever indirect register the pointer selects. The indirect registers hold:

- the clock low and clock high period counts,
- a timeout value,
- a transfer count with a last-byte flag,
- a two-bit speed-mode field,
- a write-only unlock port.

Each field also drives a dedicated output that the serial engine uses.

A soft reset needs two keyed bytes, written one after the other to the unlock port. When the sequence completes, the block raises a one-cycle `soft_rst` pulse, and that pulse restores every indirect register to its default. Any stray access breaks the sequence, and so does a wrong key. After each pulse, the first byte written to the unlock port is discarded. This lowers the chance that runaway host code resets the controller a second time.

Top module: `ireg_port`

## Requirements
- R1: A write with `win_sel`=0 loads the pointer from `wr_data[2:0]`. While `win_sel`=0, `rd_data` returns the pointer zero-extended to eight bits.
- R2: A write with `win_sel`=1 stores the byte in the register the pointer selects, and `rd_data` returns it: pointer 2 is the clock low count, 3 is the clock high count, 4 is the timeout. Each is a full byte and appears on its own output.
- R3: Pointer 0 selects the transfer-count register. Bits [6:0] are the byte count on `xfer_cnt`, and bit 7 is the last-byte flag on `last_byte`.
- R4: Pointer 6 selects the mode register. Only bits [1:0] are stored, as `speed_mode` (0 standard, 1 fast, 2 fast-plus). Its upper read bits are 0.
- R5: Pointer 5 (unlock port), pointer 1 (reserved) and pointer 7 (unmapped) all read 0. Writes to them change no stored register.
- R6: When the unlock port receives A5h and then 5Ah, with no other access between the two, `soft_rst` is high for exactly the one cycle after the 5Ah write.
- R7: In the cycle after the pulse, all indirect registers are back at their defaults: clock low 9Dh, clock high 86h, timeout FFh, count 00h, mode 0. The pointer keeps its value.
- R8: A write to the unlock port other than 5Ah while waiting for the second key returns the detector to idle. A5h, A5h, 5Ah gives no pulse.
- R9: Any access between the two keys aborts the sequence. This covers a pointer write, a window read, or any other read or write.
- R10: After a pulse, the next write to the unlock port is discarded by the detector, whatever its value.
- R11: An active-high synchronous `rst` loads the register defaults, clears the pointer and the pulse, and idles the detector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_sel | input | 1 | 0 selects the pointer, 1 selects the data window |
| wr_en | input | 1 | Host write strobe, one cycle per byte |
| rd_en | input | 1 | Host read strobe, one cycle per byte |
| wr_data | input | 8 | Host write byte |
| rd_data | output | 8 | Read byte for the selected location |
| soft_rst | output | 1 | One-cycle soft reset pulse |
| clk_lo_cnt | output | 8 | Clock low period count |
| clk_hi_cnt | output | 8 | Clock high period count |
| tmo_val | output | 8 | Timeout value |
| xfer_cnt | output | 7 | Transfer byte count |
| last_byte | output | 1 | Last-byte control flag |
| speed_mode | output | 2 | Bus speed mode |

## Verification
Some properties are checked on every cycle:

- the pulse lasts one cycle and follows a 5Ah write to the unlock port;
- registers hold their defaults after the pulse;
- writes to unmapped or write-only pointers leave the registers stable;
- an abort or a wrong key returns the detector to idle;
- the swallowed byte after a pulse produces no pulse;
- the pointer loads from the low three bits.

The ordering matters only across whole scenarios, and only the bench's scenarios can show it. These include the swallowed byte followed by a clean unlock, a double A5h, an abort by a read, and read-back of every field through the window.

// File: rtl/ireg_pkg.sv
package ireg_pkg;
    localparam int DATA_W = 8;
    localparam int PTR_W  = 3;
    localparam int CNT_W  = 7;
    localparam int MODE_W = 2;

    typedef enum logic [PTR_W-1:0] {
        IX_COUNT  = 3'd0,
        IX_SPARE  = 3'd1,
        IX_CLKLO  = 3'd2,
        IX_CLKHI  = 3'd3,
        IX_TMO    = 3'd4,
        IX_UNLOCK = 3'd5,
        IX_MODE   = 3'd6
    } ix_e;

    localparam logic [DATA_W-1:0] KEY_FIRST  = 8'hA5;
    localparam logic [DATA_W-1:0] KEY_SECOND = 8'h5A;

    typedef enum logic [1:0] {UL_IDLE, UL_ARMED, UL_SKIP} ul_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] clk_lo;
        logic [DATA_W-1:0] clk_hi;
        logic [DATA_W-1:0] tmo;
        logic              last;
        logic [CNT_W-1:0]  cnt;
        logic [MODE_W-1:0] mode;
    } cfg_t;

    localparam cfg_t CFG_DEF = '{clk_lo: 8'h9D, clk_hi: 8'h86, tmo: 8'hFF,
                                 last: 1'b0, cnt: '0, mode: '0};

    function automatic logic [DATA_W-1:0] read_mux(input cfg_t c, input logic [PTR_W-1:0] p);
        logic [DATA_W-1:0] r;
        case (p)
            IX_COUNT: r = {c.last, c.cnt};
            IX_CLKLO: r = c.clk_lo;
            IX_CLKHI: r = c.clk_hi;
            IX_TMO:   r = c.tmo;
            IX_MODE:  r = {{(DATA_W-MODE_W){1'b0}}, c.mode};
            default:  r = '0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/ireg_ptr.sv
module ireg_ptr
    import ireg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             win_sel,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [PTR_W-1:0] ptr_din,
    output logic [PTR_W-1:0] ptr,
    output logic             win_wr,
    output logic             key_wr,
    output logic             other_acc
);
    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (wr_en && !win_sel)
            ptr <= ptr_din;
    end

    always_comb begin
        win_wr    = wr_en && win_sel;
        key_wr    = win_wr && (ptr == IX_UNLOCK);
        other_acc = (wr_en || rd_en) && !key_wr;
    end

    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !win_sel) |=> (ptr == $past(ptr_din))); // R1
endmodule

// File: rtl/ireg_file.sv
module ireg_file
    import ireg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              win_wr,
    input  logic [PTR_W-1:0]  ptr,
    input  logic [DATA_W-1:0] wr_data,
    output cfg_t              cfg
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cfg <= CFG_DEF;
        end else if (win_wr) begin
            case (ptr)
                IX_COUNT: {cfg.last, cfg.cnt} <= wr_data;
                IX_CLKLO: cfg.clk_lo <= wr_data;
                IX_CLKHI: cfg.clk_hi <= wr_data;
                IX_TMO:   cfg.tmo    <= wr_data;
                IX_MODE:  cfg.mode   <= wr_data[MODE_W-1:0];
                default:  ;
            endcase
        end
    end

    AST_CLEAR_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
        $past(clear) |-> (cfg == CFG_DEF)); // R7

    AST_DEAD_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (win_wr && !clear && (ptr == IX_SPARE || ptr == IX_UNLOCK || ptr == 3'd7))
        |=> $stable(cfg)); // R5
endmodule

// File: rtl/ireg_unlock.sv
module ireg_unlock
    import ireg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              key_wr,
    input  logic              other_acc,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pulse
);
    ul_state_e st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= UL_IDLE;
            pulse <= 1'b0;
        end else begin
            pulse <= 1'b0;
            case (st)
                UL_IDLE:  if (key_wr && wr_data == KEY_FIRST) st <= UL_ARMED;
                UL_ARMED: begin
                    if (key_wr) begin
                        if (wr_data == KEY_SECOND) begin
                            pulse <= 1'b1;
                            st    <= UL_SKIP;
                        end else begin
                            st <= UL_IDLE;
                        end
                    end else if (other_acc) begin
                        st <= UL_IDLE;
                    end
                end
                UL_SKIP:  if (key_wr) st <= UL_IDLE;
                default:  st <= UL_IDLE;
            endcase
        end
    end

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse); // R6
    AST_PULSE_AFTER_KEY: assert property (@(posedge clk) disable iff (rst)
        pulse |-> $past(key_wr && wr_data == KEY_SECOND)); // R6
    AST_WRONG_KEY_IDLE: assert property (@(posedge clk) disable iff (rst)
        (st == UL_ARMED && key_wr && wr_data != KEY_SECOND) |=> (st == UL_IDLE && !pulse)); // R8
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (st == UL_ARMED && other_acc) |=> (st == UL_IDLE && !pulse)); // R9
    AST_SKIP_SWALLOW: assert property (@(posedge clk) disable iff (rst)
        (st == UL_SKIP && key_wr) |=> (st == UL_IDLE && !pulse)); // R10
endmodule

// File: rtl/ireg_port.sv
module ireg_port
    import ireg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              win_sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              soft_rst,
    output logic [DATA_W-1:0] clk_lo_cnt,
    output logic [DATA_W-1:0] clk_hi_cnt,
    output logic [DATA_W-1:0] tmo_val,
    output logic [CNT_W-1:0]  xfer_cnt,
    output logic              last_byte,
    output logic [MODE_W-1:0] speed_mode
);
    logic [PTR_W-1:0] ptr;
    logic             win_wr, key_wr, other_acc;
    cfg_t             cfg;

    ireg_ptr u_ptr (
        .clk(clk), .rst(rst), .win_sel(win_sel), .wr_en(wr_en), .rd_en(rd_en),
        .ptr_din(wr_data[PTR_W-1:0]), .ptr(ptr), .win_wr(win_wr),
        .key_wr(key_wr), .other_acc(other_acc)
    );

    ireg_unlock u_unlock (
        .clk(clk), .rst(rst), .key_wr(key_wr), .other_acc(other_acc),
        .wr_data(wr_data), .pulse(soft_rst)
    );

    ireg_file u_file (
        .clk(clk), .rst(rst), .clear(soft_rst), .win_wr(win_wr),
        .ptr(ptr), .wr_data(wr_data), .cfg(cfg)
    );

    always_comb begin
        rd_data    = win_sel ? read_mux(cfg, ptr) : {{(DATA_W-PTR_W){1'b0}}, ptr};
        clk_lo_cnt = cfg.clk_lo;
        clk_hi_cnt = cfg.clk_hi;
        tmo_val    = cfg.tmo;
        xfer_cnt   = cfg.cnt;
        last_byte  = cfg.last;
        speed_mode = cfg.mode;
    end
endmodule

// File: tb/ireg_port_tb.sv
module ireg_port_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       win_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data, clk_lo_cnt, clk_hi_cnt, tmo_val;
    logic       soft_rst, last_byte;
    logic [6:0] xfer_cnt;
    logic [1:0] speed_mode;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ireg_port dut_i (
        .clk(clk), .rst(rst), .win_sel(win_sel), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .soft_rst(soft_rst),
        .clk_lo_cnt(clk_lo_cnt), .clk_hi_cnt(clk_hi_cnt), .tmo_val(tmo_val),
        .xfer_cnt(xfer_cnt), .last_byte(last_byte), .speed_mode(speed_mode)
    );

    // behavioural reference model
    int  m_ptr, m_lo, m_hi, m_to, m_cnt, m_mode, m_st;
    bit  m_pulse;

    task automatic model_defaults();
        m_lo = 'h9D; m_hi = 'h86; m_to = 'hFF; m_cnt = 0; m_mode = 0;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            model_defaults(); m_ptr = 0; m_st = 0; m_pulse = 0;
        end else begin
            bit keyw, nxt_pulse;
            keyw = wr_en && win_sel && (m_ptr == 5);
            nxt_pulse = 0;
            if (m_pulse) model_defaults();
            else if (wr_en && win_sel) begin
                if (m_ptr == 0) m_cnt = wr_data;
                if (m_ptr == 2) m_lo = wr_data;
                if (m_ptr == 3) m_hi = wr_data;
                if (m_ptr == 4) m_to = wr_data;
                if (m_ptr == 6) m_mode = wr_data % 4;
            end
            if (m_st == 0) begin
                if (keyw && wr_data == 8'hA5) m_st = 1;
            end else if (m_st == 1) begin
                if (keyw) begin
                    if (wr_data == 8'h5A) begin nxt_pulse = 1; m_st = 2; end
                    else m_st = 0;
                end else if (wr_en || rd_en) m_st = 0;
            end else if (keyw) m_st = 0;
            m_pulse = nxt_pulse;
            if (wr_en && !win_sel) m_ptr = wr_data % 8;
        end
    end

    function automatic int model_rd();
        if (!win_sel) return m_ptr;
        case (m_ptr)
            0: return m_cnt;
            2: return m_lo;
            3: return m_hi;
            4: return m_to;
            6: return m_mode;
            default: return 0;
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // compare on every clock, midway between edges
    always @(posedge clk) begin
        #5;
        if (!done) begin
            check("R2 rd_data", rd_data, model_rd());
            check("R6 soft_rst", soft_rst, m_pulse);
            check("R2 clk_lo", clk_lo_cnt, m_lo);
            check("R2 clk_hi", clk_hi_cnt, m_hi);
            check("R2 tmo", tmo_val, m_to);
            check("R3 count", {last_byte, xfer_cnt}, m_cnt);
            check("R4 mode", speed_mode, m_mode);
        end
    end

    bit saw_pulse;
    always @(posedge clk) #5 if (soft_rst) saw_pulse = 1;

    task automatic op(bit sel, bit wr, bit [7:0] d);
        @(negedge clk);
        win_sel = sel; wr_en = wr; rd_en = !wr; wr_data = d;
        @(negedge clk);
        wr_en = 0; rd_en = 0;
    endtask

    task automatic rd_chk(bit sel, int exp, string req);
        @(negedge clk);
        win_sel = sel; rd_en = 1;
        #5 check(req, rd_data, exp);
        @(negedge clk);
        rd_en = 0;
    endtask

    task automatic wr_ind(bit [2:0] p, bit [7:0] d);
        op(0, 1, {5'b0, p});
        op(1, 1, d);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        failures++; checks++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        idle(1);
        // R11 reset state
        check("R11 lo", clk_lo_cnt, 'h9D);
        check("R11 to", tmo_val, 'hFF);
        check("R11 pulse", soft_rst, 0);
        rd_chk(0, 0, "R11 ptr");
        // R1 pointer
        op(0, 1, 8'h06); rd_chk(0, 6, "R1 ptr6");
        op(0, 1, 8'h0F); rd_chk(0, 7, "R1 low bits");
        // R2 byte registers
        wr_ind(2, 8'h33); wr_ind(3, 8'h44); wr_ind(4, 8'h55);
        op(0, 1, 2); rd_chk(1, 'h33, "R2 lo");
        op(0, 1, 3); rd_chk(1, 'h44, "R2 hi");
        op(0, 1, 4); rd_chk(1, 'h55, "R2 to");
        // R3 count
        wr_ind(0, 8'hC5); idle(1);
        check("R3 cnt", xfer_cnt, 'h45); check("R3 last", last_byte, 1);
        rd_chk(1, 'hC5, "R3 read");
        // R4 mode
        wr_ind(6, 8'hFE); idle(1);
        check("R4 speed", speed_mode, 2); rd_chk(1, 2, "R4 read");
        // R5 dead pointers
        wr_ind(1, 8'h77); rd_chk(1, 0, "R5 spare");
        wr_ind(7, 8'h66); rd_chk(1, 0, "R5 unmapped");
        check("R5 hold", clk_lo_cnt, 'h33);
        op(0, 1, 5); rd_chk(1, 0, "R5 unlock reads 0");
        // R6/R7 unlock
        saw_pulse = 0;
        op(1, 1, 8'hA5); op(1, 1, 8'h5A); idle(1);
        check("R6 pulse seen", saw_pulse, 1);
        check("R7 lo default", clk_lo_cnt, 'h9D);
        check("R7 mode default", speed_mode, 0);
        rd_chk(0, 5, "R7 ptr kept");
        // R10 swallow
        saw_pulse = 0;
        op(1, 1, 8'hA5); op(1, 1, 8'h5A); idle(1);
        check("R10 no pulse", saw_pulse, 0);
        op(1, 1, 8'hA5); op(1, 1, 8'h5A); idle(1);
        check("R10 clean unlock", saw_pulse, 1);
        op(1, 1, 8'h00);
        // R8 wrong key
        wr_ind(2, 8'h12); op(0, 1, 5);
        saw_pulse = 0;
        op(1, 1, 8'hA5); op(1, 1, 8'h33); op(1, 1, 8'h5A); idle(1);
        check("R8 bad key", saw_pulse, 0);
        op(1, 1, 8'hA5); op(1, 1, 8'hA5); op(1, 1, 8'h5A); idle(1);
        check("R8 double first", saw_pulse, 0);
        check("R8 regs kept", clk_lo_cnt, 'h12);
        // R9 abort
        op(1, 1, 8'hA5); op(0, 1, 8'h05); op(1, 1, 8'h5A); idle(1);
        check("R9 ptr write abort", saw_pulse, 0);
        op(1, 1, 8'hA5); op(1, 0, 8'h00); op(1, 1, 8'h5A); idle(1);
        check("R9 read abort", saw_pulse, 0);
        op(1, 1, 8'hA5); op(1, 1, 8'h5A); idle(1);
        check("R9 then unlock", saw_pulse, 1);
        // R11 mid-run reset
        wr_ind(4, 8'h01);
        @(negedge clk); rst = 1; @(negedge clk); rst = 0;
        idle(1);
        check("R11 to reset", tmo_val, 'hFF);
        rd_chk(0, 0, "R11 ptr reset");
        idle(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule